// File: doc/BRIEF.md
# Watchdog Clock Control with Write-Once Protection

This block holds the configuration that steers the clock of a watchdog counter. A single control register selects one of three clock sources (ring, sub or main oscillator), a power-of-two division ratio, and two stop-control bits used when the chip enters a low-power mode. Each source is modelled as a clock-enable pulse in one system-clock domain. The divider turns the pulses of the selected source into one watchdog tick-enable output.

The control register is guarded twice. First, it only changes through an unlock sequence: the key value 0xA5 is written to a command register, and the next bus access must be the write to the control register. Second, it takes only one successful write per reset. Any later write, even a correctly unlocked one, is dropped without notice.

A sticky error flag records broken unlock sequences. It is not set by a correctly unlocked write that arrives after the register is already locked. Software clears the flag by writing 0 to bit 0 of the status register.

Top module: `wcc_wdt_clkctl`

## Requirements
- R1: After reset the control register reads 0x40 and the status register reads 0x00. Control register layout: bits [2:0] division code, bits [4:3] source code, bit 5 ring-stop enable, bit 6 sub-stop enable, bit 7 reads 0. Register addresses: 0 is control, 1 is command, 2 is status (bit 0 holds the error flag). Reads of any other address return 0.
- R2: When the control register is unlocked and not yet locked, a control write that comes on the bus access right after a command write of 0xA5 updates the register. That write then locks the register.
- R3: Once locked, every later control write leaves the register unchanged until reset. A locked write that was correctly unlocked leaves the error flag at 0.
- R4: A control write that does not come right after a 0xA5 command write sets the error flag and leaves the register unchanged.
- R5: After a 0xA5 command write, any other bus access sets the error flag and cancels the unlock. This covers a read, a command write of another value, and a status write. When such an access is a status write of 0, the error flag still ends at 1.
- R6: The error flag stays set until reset or a status write with bit 0 = 0. A status write with bit 0 = 1 leaves the flag unchanged.
- R7: With division code k, the tick output pulses once for every 2^k enable pulses of the selected source. The pulse appears in the cycle after the pulse that completes each group. The group count restarts when the register is written.
- R8: Source code 0 selects the ring pulses, code 1 the sub pulses and code 2 the main pulses. Pulses of unselected sources have no effect on the tick.
- R9: A successful write with source code 3 keeps the previous source code. The other fields of that write still apply, and the register still locks.
- R10: Power-mode input encoding: 0 run, 1 watch, 2 sub-watch, 3 stop. With ring-stop enable = 1 and the mode at 1, 2 or 3, ring_stop_o is 1 and ring pulses are blocked from the divider. Otherwise ring_stop_o is 0 and ring pulses pass.
- R11: With sub-stop enable = 1 and the mode at 3, sub_stop_o is 1 and sub pulses are blocked. Otherwise sub_stop_o is 0. Sub-stop enable is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or external) |
| bus_valid_i | input | 1 | A bus access is present this cycle |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of a read |
| perr_o | output | 1 | Sticky error flag for a broken unlock sequence |
| pmode_i | input | 2 | Low-power mode in effect |
| ring_en_i | input | 1 | Ring oscillator enable pulse |
| sub_en_i | input | 1 | Sub oscillator enable pulse |
| main_en_i | input | 1 | Main oscillator enable pulse |
| ring_stop_o | output | 1 | Request to stop the ring oscillator |
| sub_stop_o | output | 1 | Request to stop the sub oscillator |
| wdt_tick_o | output | 1 | Watchdog tick enable |

## Verification
Each register effect of a write appears in the first cycle after the clock edge that takes the write. The combinational read data and the stop outputs settle within the same cycle as their inputs. The tick output is registered, so it pulses one cycle after the source pulse that completes a group of 2^k.

The bench drives every input just after a falling edge and reads the results at the next falling edge, which is exactly one rising edge later. Read data is taken a nanosecond after the read is driven, before the edge that consumes it. The expected tick of each cycle is computed from the pulse the bench drove in the cycle before.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
  localparam int DIV_W  = 3;
  localparam int SRC_W  = 2;
  localparam int NSRC   = 3;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'hA5;

  localparam logic [SRC_W-1:0] SRC_RING = 2'd0;
  localparam logic [SRC_W-1:0] SRC_SUB  = 2'd1;
  localparam logic [SRC_W-1:0] SRC_MAIN = 2'd2;
  localparam logic [SRC_W-1:0] SRC_BAD  = 2'd3;

  typedef enum logic [1:0] {
    PM_RUN      = 2'd0,
    PM_WATCH    = 2'd1,
    PM_SUBWATCH = 2'd2,
    PM_STOP     = 2'd3
  } pmode_e;

  typedef struct packed {
    logic             sub_stop;
    logic             ring_stop;
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam cfg_t CFG_RST = '{sub_stop: 1'b1, ring_stop: 1'b0,
                               src: SRC_RING, div: '0};
endpackage

// File: rtl/wcc_rst_sync.sv
module wcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wcc_prot.sv
module wcc_prot
  import wcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output cfg_t              cfg_o,
  output logic              cfg_load_o,
  output logic              perr_o
);
  cfg_t cfg_q, cfg_d, cfg_wr;
  logic armed_q, armed_d;
  logic locked_q, locked_d;
  logic perr_q, perr_d;
  logic wr_acc, ctrl_wr, key_wr, stat_clr, violation, commit;

  // access decode
  always_comb begin
    wr_acc   = bus_valid && bus_write;
    ctrl_wr  = wr_acc && (bus_addr == A_CTRL);
    key_wr   = wr_acc && (bus_addr == A_CMD) && (bus_wdata == UNLOCK_KEY);
    stat_clr = wr_acc && (bus_addr == A_STAT) && !bus_wdata[0];
  end

  // sequence and lock next state
  always_comb begin
    violation = (ctrl_wr && !armed_q) || (bus_valid && armed_q && !ctrl_wr);
    commit    = ctrl_wr && armed_q && !locked_q;

    if (key_wr) begin
      armed_d = 1'b1;
    end else if (bus_valid) begin
      armed_d = 1'b0;
    end else begin
      armed_d = armed_q;
    end

    locked_d = locked_q || commit;

    if (violation) begin
      perr_d = 1'b1;
    end else if (stat_clr) begin
      perr_d = 1'b0;
    end else begin
      perr_d = perr_q;
    end

    cfg_wr = cfg_t'(bus_wdata[CFG_W-1:0]);
    if (cfg_wr.src == SRC_BAD) begin
      cfg_wr.src = cfg_q.src;
    end
    cfg_d = commit ? cfg_wr : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      perr_q   <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      locked_q <= locked_d;
      perr_q   <= perr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (commit) begin
      cfg_q <= cfg_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_CTRL:  bus_rdata[CFG_W-1:0] = cfg_q;
        A_STAT:  bus_rdata[0]         = perr_q;
        default: bus_rdata            = '0;
      endcase
    end
  end

  assign cfg_o      = cfg_q;
  assign cfg_load_o = commit;
  assign perr_o     = perr_q;

  // R2: an accepted write engages the lock
  p_commit_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> locked_q);

  // R3: a locked register never changes
  p_locked_cfg_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cfg_q));

  // R3: an unlocked write to a locked register raises no error
  p_relock_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && armed_q && locked_q && !perr_q) |=> !perr_q);

  // R4: a control write without the key raises the error
  p_unkeyed_write_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !armed_q) |=> perr_q);

  // R6: the flag holds unless cleared
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q && !stat_clr) |=> perr_q);

  // R9: the forbidden source code never reaches the register
  p_src_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.src != SRC_BAD);
endmodule

// File: rtl/wcc_gate.sv
module wcc_gate
  import wcc_pkg::*;
(
  input  logic [1:0]      pmode,
  input  logic            ring_stop_en,
  input  logic            sub_stop_en,
  input  logic [NSRC-1:0] en_raw,
  output logic [NSRC-1:0] en_gated,
  output logic            ring_off,
  output logic            sub_off
);
  pmode_e mode;

  always_comb begin
    mode     = pmode_e'(pmode);
    ring_off = ring_stop_en && (mode != PM_RUN);
    sub_off  = sub_stop_en && (mode == PM_STOP);
    en_gated = en_raw;
    if (ring_off) begin
      en_gated[SRC_RING] = 1'b0;
    end
    if (sub_off) begin
      en_gated[SRC_SUB] = 1'b0;
    end
  end
endmodule

// File: rtl/wcc_div.sv
module wcc_div
  import wcc_pkg::*;
#(
  parameter int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  en_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, mask;
  logic             sel_en, tick_q, tick_d;

  always_comb begin
    sel_en = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (src_i == SRC_W'(k)) begin
        sel_en = en_i[k];
      end
    end
  end

  always_comb begin
    mask   = ~({CNT_W{1'b1}} << div_i);
    tick_d = sel_en && ((cnt_q & mask) == mask);
    if (clr_i) begin
      cnt_d = '0;
    end else if (sel_en) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R7: every tick follows a pulse of the selected source
  p_tick_after_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(sel_en));

  // R7: at divide-by-1 every selected pulse ticks
  p_div1_every_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && div_i == '0) |=> tick_q);
endmodule

// File: rtl/wcc_wdt_clkctl.sv
module wcc_wdt_clkctl
  import wcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid_i,
  input  logic       bus_write_i,
  input  logic [1:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       perr_o,
  input  logic [1:0] pmode_i,
  input  logic       ring_en_i,
  input  logic       sub_en_i,
  input  logic       main_en_i,
  output logic       ring_stop_o,
  output logic       sub_stop_o,
  output logic       wdt_tick_o
);
  logic            srst_n;
  cfg_t            cfg;
  logic            cfg_load;
  logic [NSRC-1:0] en_raw, en_gated;

  wcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wcc_prot u_prot (
    .clk        (clk),
    .rst_n      (srst_n),
    .bus_valid  (bus_valid_i),
    .bus_write  (bus_write_i),
    .bus_addr   (bus_addr_i),
    .bus_wdata  (bus_wdata_i),
    .bus_rdata  (bus_rdata_o),
    .cfg_o      (cfg),
    .cfg_load_o (cfg_load),
    .perr_o     (perr_o)
  );

  always_comb begin
    en_raw           = '0;
    en_raw[SRC_RING] = ring_en_i;
    en_raw[SRC_SUB]  = sub_en_i;
    en_raw[SRC_MAIN] = main_en_i;
  end

  wcc_gate u_gate (
    .pmode        (pmode_i),
    .ring_stop_en (cfg.ring_stop),
    .sub_stop_en  (cfg.sub_stop),
    .en_raw       (en_raw),
    .en_gated     (en_gated),
    .ring_off     (ring_stop_o),
    .sub_off      (sub_stop_o)
  );

  wcc_div u_div (
    .clk    (clk),
    .rst_n  (srst_n),
    .en_i   (en_gated),
    .src_i  (cfg.src),
    .div_i  (cfg.div),
    .clr_i  (cfg_load),
    .tick_o (wdt_tick_o)
  );

  // R10: a stopped ring clock never produces a tick when it is the source
  p_ring_gate_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (ring_stop_o && cfg.src == SRC_RING && !cfg_load) |=> !wdt_tick_o);

  // R11: a stopped sub clock never produces a tick when it is the source
  p_sub_gate_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (sub_stop_o && cfg.src == SRC_SUB && !cfg_load) |=> !wdt_tick_o);
endmodule

// File: tb/sim_wcc_wdt_clkctl.sv
`timescale 1ns/1ps
module sim_wcc_wdt_clkctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_valid, bus_write;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       perr, ring_stop, sub_stop, tick;
  logic [1:0] pmode;
  logic       ring_en, sub_en, main_en;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wcc_wdt_clkctl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid_i (bus_valid),
    .bus_write_i (bus_write),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .perr_o      (perr),
    .pmode_i     (pmode),
    .ring_en_i   (ring_en),
    .sub_en_i    (sub_en),
    .main_en_i   (main_en),
    .ring_stop_o (ring_stop),
    .sub_stop_o  (sub_stop),
    .wdt_tick_o  (tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    ring_en = 1'b0; sub_en = 1'b0; main_en = 1'b0; pmode = 2'd0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  // one pulse on source s (0 ring, 1 sub, 2 main), then check the tick
  task automatic pulse_chk(input int s, input bit exp, input string req);
    ring_en = (s == 0); sub_en = (s == 1); main_en = (s == 2);
    @(negedge clk);
    ring_en = 1'b0; sub_en = 1'b0; main_en = 1'b0;
    check(tick == exp, req, tick, exp);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // sweep: every legal source and every division code (R7, R8)
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 8; k++) begin
        int cnt;
        bit exp_tick;
        do_reset();
        wr(2'd1, 8'hA5);
        wr(2'd0, 8'((s << 3) | k));
        cnt = 0;
        exp_tick = 1'b0;
        for (int i = 0; i < 300; i++) begin
          bit sel;
          check(tick == exp_tick, (s == 0) ? "R7 ring" : "R8 sub/main", tick, exp_tick);
          ring_en = (i % 2 == 0);
          sub_en  = (i % 3 == 1);
          main_en = (i % 7 != 3);
          sel = (s == 0) ? ring_en : (s == 1) ? sub_en : main_en;
          exp_tick = sel && ((cnt % (1 << k)) == ((1 << k) - 1));
          if (sel) cnt++;
          @(negedge clk);
        end
        ring_en = 1'b0; sub_en = 1'b0; main_en = 1'b0;
        check(tick == exp_tick, "R7 last", tick, exp_tick);
      end
    end

    // R1: reset state
    do_reset();
    check(tick == 1'b0, "R1 tick", tick, 0);
    rd_chk(2'd0, 8'h40, "R1 ctrl");
    rd_chk(2'd2, 8'h00, "R1 stat");
    rd_chk(2'd1, 8'h00, "R1 cmd reads 0");
    check(perr == 1'b0, "R1 perr", perr, 0);
    pmode = 2'd3; #1;
    check(sub_stop == 1'b1, "R11 default sub stop", sub_stop, 1);
    check(ring_stop == 1'b0, "R10 default ring runs", ring_stop, 0);
    pmode = 2'd0;
    @(negedge clk);

    // R4: control write with no key
    wr(2'd0, 8'h15);
    rd_chk(2'd2, 8'h01, "R4 err");
    rd_chk(2'd0, 8'h40, "R4 ctrl kept");

    // R6: a 1 does not clear, a 0 does
    wr(2'd2, 8'h01);
    rd_chk(2'd2, 8'h01, "R6 write 1 keeps");
    wr(2'd2, 8'h00);
    rd_chk(2'd2, 8'h00, "R6 write 0 clears");

    // R5: an intervening read breaks the sequence
    wr(2'd1, 8'hA5);
    rd_chk(2'd2, 8'h00, "R5 read before flag");
    rd_chk(2'd2, 8'h01, "R5 read breaks");
    wr(2'd0, 8'h15);
    rd_chk(2'd0, 8'h40, "R5 ctrl kept");
    wr(2'd2, 8'h00);
    // R5: a command write of another value breaks it
    wr(2'd1, 8'hA5);
    wr(2'd1, 8'h5A);
    rd_chk(2'd2, 8'h01, "R5 other cmd");
    wr(2'd2, 8'h00);
    // R5: a status clear as intervening access still leaves the flag at 1
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h00);
    rd_chk(2'd2, 8'h01, "R5 clear loses");
    wr(2'd2, 8'h00);
    rd_chk(2'd2, 8'h00, "R6 cleared again");

    // R2: unlocked write takes effect
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'h2A);
    rd_chk(2'd0, 8'h2A, "R2 ctrl");
    rd_chk(2'd2, 8'h00, "R2 no err");

    // R3: second unlocked write ignored silently
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'h07);
    rd_chk(2'd0, 8'h2A, "R3 ctrl locked");
    rd_chk(2'd2, 8'h00, "R3 no err");
    wr(2'd0, 8'h07);
    rd_chk(2'd2, 8'h01, "R4 locked unkeyed err");
    rd_chk(2'd0, 8'h2A, "R3 still locked");

    // R9: forbidden source code keeps the old source, other fields apply
    do_reset();
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'h1B);
    rd_chk(2'd0, 8'h03, "R9 fields");
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'h08);
    rd_chk(2'd0, 8'h03, "R9 locks");
    rd_chk(2'd2, 8'h00, "R9 no err");
    // R11: sub stop bit cleared by that write
    pmode = 2'd3; #1;
    check(sub_stop == 1'b0, "R11 bit cleared", sub_stop, 0);
    pmode = 2'd0;
    @(negedge clk);

    // R10: ring stop bit clear: ring runs in every mode
    do_reset();
    pmode = 2'd1;
    pulse_chk(0, 1'b1, "R10 ring passes without bit");
    check(ring_stop == 1'b0, "R10 no stop", ring_stop, 0);
    pmode = 2'd0;
    // R10: ring stop bit set
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'h20);
    pulse_chk(0, 1'b1, "R10 run passes");
    check(ring_stop == 1'b0, "R10 run no stop", ring_stop, 0);
    for (int m = 1; m < 4; m++) begin
      pmode = 2'(m); #1;
      check(ring_stop == 1'b1, "R10 stop out", ring_stop, 1);
      pulse_chk(0, 1'b0, "R10 ring blocked");
    end
    pmode = 2'd0;
    pulse_chk(0, 1'b1, "R10 back to run");

    // R11: sub stop bit set with sub selected
    do_reset();
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'h48);
    pmode = 2'd3; #1;
    check(sub_stop == 1'b1, "R11 stop out", sub_stop, 1);
    pulse_chk(1, 1'b0, "R11 sub blocked");
    pmode = 2'd1; #1;
    check(sub_stop == 1'b0, "R11 watch runs", sub_stop, 0);
    pulse_chk(1, 1'b1, "R11 sub passes in watch");
    pulse_chk(2, 1'b0, "R8 main ignored");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule